// File: doc/BRIEF.md
# Status Register with Sense-Line Interrupt Entry

This block holds the eight-bit processor status word and decides when a pending request on the first sense line becomes an interrupt. Three low status bits drive general-purpose flag pins directly. Bit 3 is the interrupt enable. Bits 4 and 5 show the two sense input pins after they pass through a synchronizer. The top two bits hold overflow and carry/link, and the arithmetic unit supplies both. The accumulator can write the whole word in one cycle, and the word can be read back at any time.

Interrupt entry happens at instruction boundaries. On a clock where the boundary strobe is high, the stored enable is set, and synchronized sense A is high, the block clears the enable. On the next cycle it raises a one-cycle exchange request to the pointer unit, which swaps the program counter with the link pointer. The normal increment-before-fetch step then starts the handler one address past the link pointer's old value. There is no stack and no hardware return path. Software returns with the same exchange and sets the enable again with its own command.

Top module: `status_irq_unit`

## Requirements
- R1: After reset, the status read port is 8'h00 when both sense pins are low, the flag pins are 0, and the exchange request is low.
- R2: The flag pins always equal status bits 2:0, and a load from the accumulator sets them to the accumulator's bits 2:0 from the next clock.
- R3: A status load copies accumulator bits 7, 6, 3, 2, 1 and 0 into the same bit positions from the next clock. Accumulator bits 5:4 are ignored, so read bits 5:4 keep showing the sense inputs.
- R4: Read bit 4 shows the sense A pin and read bit 5 shows the sense B pin, each delayed by two clock edges through a synchronizer.
- R5: The set-enable command sets bit 3 and the clear-enable command clears it. When both are given in the same clock, clear wins. A status load in that clock overrides both commands.
- R6: When the ALU flag strobe is high, bit 6 takes the overflow input and bit 7 takes the carry input. A status load in the same clock takes precedence.
- R7: An interrupt is taken on a clock where the boundary strobe is high, the stored enable is 1, and synchronized sense A is 1. After that clock the enable reads 0 and the exchange request is high for exactly one cycle.
- R8: No interrupt is taken while the boundary strobe is low, while the enable is 0, or while sense A is low. Sense B never causes an interrupt.
- R9: The enable value stored before the clock decides whether an interrupt is taken, even if an enable or disable command falls in the same clock. A taken interrupt leaves the enable at 0 whatever command or load came with it.
- R10: The exchange request is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_a_pin | input | 1 | Sense line A, also the interrupt request, asynchronous |
| sense_b_pin | input | 1 | Sense line B, asynchronous |
| insn_boundary | input | 1 | High on the clock that ends an instruction |
| ie_set_cmd | input | 1 | Enable-interrupt command |
| ie_clr_cmd | input | 1 | Disable-interrupt command |
| sr_load | input | 1 | Load the status word from the accumulator |
| acc_in | input | 8 | Accumulator value for a status load |
| alu_flag_we | input | 1 | Write strobe for the overflow and carry inputs |
| alu_ovf | input | 1 | Overflow from the arithmetic unit |
| alu_carry | input | 1 | Carry/link from the arithmetic unit |
| sr_rd | output | 8 | Status word as read by the accumulator |
| flag_pins | output | 3 | Flag output pins, equal to status bits 2:0 |
| xchg_req | output | 1 | One-cycle request to swap the program counter and the link pointer |

## Verification
The boundary strobe, the enable and disable commands, and a status load can all arrive in one clock. The interrupt decision has to use the old enable, and the new enable has to follow the fixed priority. The bench provokes this by sweeping every combination of stored enable, set, clear, boundary and synchronized sense A, one clock each. It judges the exchange request and read bit 3 against values computed from the priority rule. A second collision, a status load against an ALU flag update in the same clock, is swept the same way against bits 7:6.

// File: rtl/stirq_pkg.sv
package stirq_pkg;
  localparam int SR_W      = 8;
  localparam int FLAG_W    = 3;
  localparam int SENSE_W   = 2;
  localparam int IE_BIT    = 3;
  localparam int SA_BIT    = 4;
  localparam int OV_BIT    = 6;
  localparam int CY_BIT    = 7;
  localparam logic [SR_W-1:0] WR_MASK = 8'hCF;

  // next enable: taken interrupt > load > clear > set > hold
  function automatic logic ie_next(input logic ie_q, input logic take,
                                   input logic ld, input logic ld_bit,
                                   input logic clr, input logic set);
    if (take)     return 1'b0;
    else if (ld)  return ld_bit;
    else if (clr) return 1'b0;
    else if (set) return 1'b1;
    else          return ie_q;
  endfunction

  function automatic logic irq_take(input logic bnd, input logic ie_q,
                                    input logic sa);
    return bnd & ie_q & sa;
  endfunction
endpackage

// File: rtl/sense_sync.sv
module sense_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/status_core.sv
module status_core
  import stirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SENSE_W-1:0] sense_s,
  input  logic               take,
  input  logic               ie_set_cmd,
  input  logic               ie_clr_cmd,
  input  logic               sr_load,
  input  logic [SR_W-1:0]    acc_in,
  input  logic               alu_flag_we,
  input  logic               alu_ovf,
  input  logic               alu_carry,
  output logic               ie_q,
  output logic [SR_W-1:0]    sr_rd,
  output logic [FLAG_W-1:0]  flag_pins
);
  logic [SR_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (alu_flag_we) begin
      sr_d[CY_BIT] = alu_carry;
      sr_d[OV_BIT] = alu_ovf;
    end
    if (sr_load) sr_d = acc_in & WR_MASK;
    sr_d[IE_BIT] = ie_next(sr_q[IE_BIT], take, sr_load, acc_in[IE_BIT],
                           ie_clr_cmd, ie_set_cmd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign ie_q      = sr_q[IE_BIT];
  assign flag_pins = sr_q[FLAG_W-1:0];
  assign sr_rd     = sr_q | ({{(SR_W-SENSE_W){1'b0}}, sense_s} << SA_BIT);

  a_r2_load_drives_pins: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |=> flag_pins == $past(acc_in[FLAG_W-1:0]));
  a_r6_alu_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_flag_we && !sr_load) |=>
      (sr_rd[CY_BIT] == $past(alu_carry)) && (sr_rd[OV_BIT] == $past(alu_ovf)));
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_clr_cmd && !sr_load) |=> !ie_q);
  a_r9_take_beats_set: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (ie_set_cmd || sr_load)) |=> !ie_q);
endmodule

// File: rtl/irq_entry.sv
module irq_entry
  import stirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic insn_boundary,
  input  logic ie_q,
  input  logic sense_a_s,
  output logic take,
  output logic xchg_req
);
  assign take = irq_take(insn_boundary, ie_q, sense_a_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xchg_req <= 1'b0;
    else        xchg_req <= take;
  end

  a_r7_entry: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (xchg_req && !ie_q));
  a_r8_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_boundary |=> !xchg_req);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_req |=> !xchg_req);
endmodule

// File: rtl/status_irq_unit.sv
module status_irq_unit
  import stirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sense_a_pin,
  input  logic        sense_b_pin,
  input  logic        insn_boundary,
  input  logic        ie_set_cmd,
  input  logic        ie_clr_cmd,
  input  logic        sr_load,
  input  logic [7:0]  acc_in,
  input  logic        alu_flag_we,
  input  logic        alu_ovf,
  input  logic        alu_carry,
  output logic [7:0]  sr_rd,
  output logic [2:0]  flag_pins,
  output logic        xchg_req
);
  logic [SENSE_W-1:0] sense_s;
  logic ie_q, take;

  sense_sync #(.STAGES(SYNC_STAGES), .WIDTH(SENSE_W)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({sense_b_pin, sense_a_pin}), .sync_out(sense_s));

  status_core u_core (
    .clk(clk), .rst_n(rst_n), .sense_s(sense_s), .take(take),
    .ie_set_cmd(ie_set_cmd), .ie_clr_cmd(ie_clr_cmd), .sr_load(sr_load),
    .acc_in(acc_in), .alu_flag_we(alu_flag_we), .alu_ovf(alu_ovf),
    .alu_carry(alu_carry), .ie_q(ie_q), .sr_rd(sr_rd), .flag_pins(flag_pins));

  irq_entry u_irq (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .ie_q(ie_q),
    .sense_a_s(sense_s[0]), .take(take), .xchg_req(xchg_req));
endmodule

// File: tb/sim_status_irq_unit.sv
`timescale 1ns/1ps
module sim_status_irq_unit;
  logic clk = 0, rst_n = 0;
  logic sa = 0, sb = 0, bnd = 0, iset = 0, iclr = 0, ld = 0, we = 0, ov = 0, cy = 0;
  logic [7:0] acc = 0;
  logic [7:0] rd;
  logic [2:0] pins;
  logic xr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  status_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .sense_a_pin(sa), .sense_b_pin(sb),
    .insn_boundary(bnd), .ie_set_cmd(iset), .ie_clr_cmd(iclr), .sr_load(ld),
    .acc_in(acc), .alu_flag_we(we), .alu_ovf(ov), .alu_carry(cy),
    .sr_rd(rd), .flag_pins(pins), .xchg_req(xr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic idle();
    bnd = 0; iset = 0; iclr = 0; ld = 0; we = 0; ov = 0; cy = 0; acc = 0;
  endtask

  task automatic load(input logic [7:0] v);
    ld = 1; acc = v; cyc(); ld = 0; acc = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 sr", rd, 8'h00);
    chk("R1 pins", pins, 3'd0);
    chk("R1 xchg", xr, 1'b0);

    // R2 R3: exhaustive accumulator load, sense pins low
    for (int v = 0; v < 256; v++) begin
      load(v[7:0]);
      chk("R3 load", rd, v & 8'hCF);
      chk("R2 pins", pins, v[2:0]);
    end
    load(8'h00);

    // R4 synchronizer delay and bit placement
    sa = 1; sb = 0; cyc();
    chk("R4 a one edge", rd[4], 1'b0);
    cyc();
    chk("R4 a two edges", rd[5:4], 2'b01);
    sa = 0; sb = 1; cyc(); cyc();
    chk("R4 b two edges", rd[5:4], 2'b10);
    // R3 sense bits ignore load while pins drive them
    load(8'h00);
    chk("R3 sense kept", rd, 8'h20);
    load(8'h30);
    chk("R3 sense ignores acc", rd, 8'h20);
    sb = 0; cyc(); cyc();

    // R6 ALU flag write vs load
    for (int k = 0; k < 16; k++) begin
      logic [7:0] base, nv, expv;
      base = 8'h05 ^ (k[0] ? 8'hC0 : 8'h00);
      load(base);
      nv = 8'h4A ^ 8'(k * 37);
      we = k[0]; ld = k[1]; ov = k[2]; cy = k[3]; acc = nv;
      cyc();
      idle();
      if (k[1]) expv = nv & 8'hCF;
      else if (k[0]) expv = {k[3], k[2], base[5:0]};
      else expv = base;
      chk("R6 flags", rd, expv);
    end

    // R5 R7 R8 R9: sweep old ie, set, clr, boundary, sense A
    for (int k = 0; k < 32; k++) begin
      logic ie0, s, c, b, a, take, ie1;
      ie0 = k[0]; s = k[1]; c = k[2]; b = k[3]; a = k[4];
      sa = a; cyc(); cyc(); cyc();
      load(ie0 ? 8'h08 : 8'h00);
      iset = s; iclr = c; bnd = b;
      cyc();
      idle();
      take = b & ie0 & a;
      ie1 = take ? 1'b0 : (c ? 1'b0 : (s ? 1'b1 : ie0));
      chk("R7 R8 R9 xchg", xr, take);
      chk("R5 R9 ie", rd[3], ie1);
      cyc();
      chk("R10 pulse ends", xr, 1'b0);
      sa = 0;
    end

    // R9 take overrides simultaneous load of enable
    sa = 1; cyc(); cyc();
    load(8'h08);
    bnd = 1; ld = 1; acc = 8'h08; cyc(); idle();
    chk("R9 take beats load", {xr, rd[3]}, 2'b10);
    // R10 boundary held with ie re-set each cycle
    iset = 1; bnd = 1; cyc();
    chk("R10 no back to back", xr, 1'b0);
    cyc(); idle();
    chk("R7 second take after re-enable", xr, 1'b1);
    // R8 sense B never interrupts
    sa = 0; sb = 1; cyc(); cyc();
    load(8'h08);
    bnd = 1; cyc(); idle();
    chk("R8 sense b", xr, 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule